// File: doc/BRIEF.md
# Block-Paced Host Ingress Buffer

This block takes bulk data arriving from a host port that sends data in fixed-size blocks. It holds the data in a first-word-fall-through buffer and hands it to a downstream valid/ready stream. Flow control toward the host works on whole blocks. The block raises its ready flag only when the buffer has room for a complete block. Once a block has been granted, every word of that block is accepted without further checks. Between blocks the flag drops, and the room is assessed again.

The host port is 16 bits wide. The first byte of each host word sits in bits 15:8. The downstream stream is 32 bits wide and has two modes, chosen by a static mode pin while reset is held:

- In narrow mode, each buffered word is passed through zero-extended.
- In wide mode, two consecutive host words are joined into one stream word. The earlier word forms the upper half.

A synchronous active-low reset empties the buffer and clears all state. The reset may come from a host trigger or from a lost clock lock.

Top module: `hbf_ingress`

## Requirements
- R1: While `rst_n` is low, `host_ready` and `s_valid` are 0 at every clock. After reset the buffer holds no words.
- R2: `host_ready` rises only when the free space (`DEPTH` minus stored 16-bit words) is at least `BLOCK_WORDS`. From the idle state it rises one clock after room exists.
- R3: Once `host_ready` is high it stays high until exactly `BLOCK_WORDS` writes have been accepted. It then goes low for at least one clock. The buffer never accepts a write while full.
- R4: A `host_wr` pulse while `host_ready` is low is ignored. No word is stored, so the words read out afterwards are unchanged.
- R5: The oldest stored word appears on `s_data` with `s_valid` high before any handshake. A word (or pair) is removed on a clock where `s_valid` and `s_ready` are both 1. Order is preserved.
- R6: In narrow mode (`wide_mode`=0), `s_data` = {16'h0000, stored word}.
- R7: In wide mode (`wide_mode`=1), two consecutive host words A then B leave as `s_data` = {A, B}.
- R8: In wide mode, while only one word of a pair has arrived, `s_valid` stays 0.
- R9: While `s_valid` is 1 and `s_ready` is 0, `s_valid` stays 1 and `s_data` keeps its value on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wide_mode | input | 1 | 1 = pair words into 32 bits; change only during reset |
| host_ready | output | 1 | Room for a whole block is granted |
| host_wr | input | 1 | Host write strobe |
| host_data | input | 16 | Host word, first byte in bits 15:8 |
| s_valid | output | 1 | Stream word available |
| s_ready | input | 1 | Stream consumer accepts |
| s_data | output | 32 | Stream word |

## Verification
The bench builds the block with `DEPTH`=16 and `BLOCK_WORDS`=4. With these values the buffer can be filled completely, which brings the full state and the partial-room state (free space nonzero but smaller than a block) within reach. It also makes the ready gap between blocks, and the reopening after a drain, observable within a few clocks. Both stream modes are exercised after separate resets. Wide mode is driven with a deliberate pause between the halves of a pair.

// File: rtl/hbf_pkg.sv
// Shared types for the block-paced host ingress buffer.
package hbf_pkg;
    // Host-side grant state: idle (assessing room) or a block is open.
    typedef enum logic {
        GR_IDLE = 1'b0,
        GR_OPEN = 1'b1
    } grant_st_e;
endpackage

// File: rtl/hbf_fwft.sv
// First-word-fall-through buffer.
// Does: stores words in arrival order; the head word is on dout whenever
// empty is low, with no read strobe needed.
// Assumes: DEPTH is a power of two; the user never pushes when full or
// pops when empty (both are masked here anyway).
module hbf_fwft #(
    parameter int W     = 16,
    parameter int DEPTH = 2048,
    localparam int AW   = $clog2(DEPTH),
    localparam int LW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [W-1:0]  din,
    input  logic          pop,
    output logic [W-1:0]  dout,
    output logic          empty,
    output logic          full,
    output logic [LW-1:0] level
);
    localparam logic [LW-1:0] DEPTH_L = LW'(DEPTH);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr;
    logic [AW-1:0] rd_ptr;
    logic          do_push;
    logic          do_pop;

    assign empty   = (level == '0);
    assign full    = (level == DEPTH_L);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = mem[rd_ptr];

    // Storage write; contents need no reset.
    always_ff @(posedge clk) begin
        if (do_push) begin
            mem[wr_ptr] <= din;
        end
    end

    // Pointer and occupancy bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            level  <= '0;
        end else begin
            if (do_push) wr_ptr <= wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
            case ({do_push, do_pop})
                2'b10:   level <= level + 1'b1;
                2'b01:   level <= level - 1'b1;
                default: level <= level;
            endcase
        end
    end
endmodule

// File: rtl/hbf_grant.sv
// Block grant controller.
// Does: opens a block toward the host only when free space covers
// BLOCK_WORDS, then accepts exactly BLOCK_WORDS writes before closing.
// Assumes: level counts stored host words; reads only add room, so a
// granted block can never overflow.
module hbf_grant
    import hbf_pkg::*;
#(
    parameter int DEPTH       = 2048,
    parameter int BLOCK_WORDS = 512,
    localparam int LW         = $clog2(DEPTH + 1),
    localparam int CW         = $clog2(BLOCK_WORDS + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [LW-1:0] level,
    input  logic          host_wr,
    output logic          host_ready,
    output logic          accept
);
    localparam logic [LW-1:0] ROOM_LIMIT = LW'(DEPTH - BLOCK_WORDS);
    localparam logic [CW-1:0] LAST_IDX   = CW'(BLOCK_WORDS - 1);

    grant_st_e     state;
    logic [CW-1:0] taken;
    logic          room_ok;

    assign room_ok    = (level <= ROOM_LIMIT);
    assign host_ready = (state == GR_OPEN);
    assign accept     = host_wr && host_ready;

    // Grant state and count of words taken in the open block.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= GR_IDLE;
            taken <= '0;
        end else begin
            case (state)
                GR_IDLE: begin
                    taken <= '0;
                    if (room_ok) state <= GR_OPEN;
                end
                GR_OPEN: begin
                    if (accept) begin
                        if (taken == LAST_IDX) begin
                            taken <= '0;
                            state <= GR_IDLE;
                        end else begin
                            taken <= taken + 1'b1;
                        end
                    end
                end
                default: state <= GR_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/hbf_pack.sv
// Stream-side output stage.
// Does: in narrow mode passes the buffer head zero-extended; in wide mode
// holds the earlier word of a pair and presents {earlier, later}.
// Assumes: buffer is first-word-fall-through; mode is static outside reset.
module hbf_pack #(
    parameter int IW = 16,
    localparam int OW = 2 * IW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wide_mode,
    input  logic          buf_empty,
    input  logic [IW-1:0] buf_head,
    output logic          buf_pop,
    output logic          s_valid,
    input  logic          s_ready,
    output logic [OW-1:0] s_data
);
    logic [IW-1:0] upper_q;
    logic          have_upper;
    logic          grab_upper;

    assign grab_upper = wide_mode && !have_upper && !buf_empty;

    // Output view and pop request per mode.
    always_comb begin
        if (wide_mode) begin
            s_valid = have_upper && !buf_empty;
            s_data  = {upper_q, buf_head};
            buf_pop = grab_upper || (s_valid && s_ready);
        end else begin
            s_valid = !buf_empty;
            s_data  = {{IW{1'b0}}, buf_head};
            buf_pop = s_valid && s_ready;
        end
    end

    // Holding register for the upper half of a pair.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            upper_q    <= '0;
            have_upper <= 1'b0;
        end else if (grab_upper) begin
            upper_q    <= buf_head;
            have_upper <= 1'b1;
        end else if (wide_mode && s_valid && s_ready) begin
            have_upper <= 1'b0;
        end
    end
endmodule

// File: rtl/hbf_ingress.sv
// Block-paced host ingress buffer (top).
// Does: grants host blocks against buffer room, stores host words in a
// first-word-fall-through buffer and drains them as a valid/ready stream.
// Assumes: wide_mode changes only while rst_n is low; DEPTH >= BLOCK_WORDS.
module hbf_ingress #(
    parameter int DEPTH       = 2048,
    parameter int BLOCK_WORDS = 512,
    localparam int HW         = 16,
    localparam int SW         = 2 * HW,
    localparam int LW         = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wide_mode,
    output logic          host_ready,
    input  logic          host_wr,
    input  logic [HW-1:0] host_data,
    output logic          s_valid,
    input  logic          s_ready,
    output logic [SW-1:0] s_data
);
    logic          wr_accept;
    logic          fifo_pop;
    logic          fifo_empty;
    logic          fifo_full;
    logic [HW-1:0] fifo_head;
    logic [LW-1:0] fifo_level;

    hbf_grant #(
        .DEPTH      (DEPTH),
        .BLOCK_WORDS(BLOCK_WORDS)
    ) u_grant (
        .clk       (clk),
        .rst_n     (rst_n),
        .level     (fifo_level),
        .host_wr   (host_wr),
        .host_ready(host_ready),
        .accept    (wr_accept)
    );

    hbf_fwft #(
        .W    (HW),
        .DEPTH(DEPTH)
    ) u_buf (
        .clk  (clk),
        .rst_n(rst_n),
        .push (wr_accept),
        .din  (host_data),
        .pop  (fifo_pop),
        .dout (fifo_head),
        .empty(fifo_empty),
        .full (fifo_full),
        .level(fifo_level)
    );

    hbf_pack #(
        .IW(HW)
    ) u_pack (
        .clk      (clk),
        .rst_n    (rst_n),
        .wide_mode(wide_mode),
        .buf_empty(fifo_empty),
        .buf_head (fifo_head),
        .buf_pop  (fifo_pop),
        .s_valid  (s_valid),
        .s_ready  (s_ready),
        .s_data   (s_data)
    );
endmodule

// File: rtl/hbf_ingress_chk.sv
// Property checker for hbf_ingress, attached by bind.
// Does: watches grant pacing, overflow, output hold and mode formatting.
// Assumes: bound to hbf_ingress with its internal buffer signals.
module hbf_ingress_chk #(
    parameter int DEPTH       = 2048,
    parameter int BLOCK_WORDS = 512,
    localparam int LW         = $clog2(DEPTH + 1),
    localparam int CW         = $clog2(BLOCK_WORDS + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          wide_mode,
    input logic          host_ready,
    input logic          s_valid,
    input logic          s_ready,
    input logic [31:0]   s_data,
    input logic          wr_accept,
    input logic          fifo_full,
    input logic [LW-1:0] fifo_level
);
    logic [CW-1:0] seen;

    // Independent count of accepted writes modulo the block size.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen <= '0;
        end else if (wr_accept) begin
            seen <= (seen == CW'(BLOCK_WORDS - 1)) ? '0 : seen + 1'b1;
        end
    end

    a_r2_room_on_grant: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(host_ready) |-> (int'($past(fifo_level)) <= DEPTH - BLOCK_WORDS));

    a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_accept && fifo_full));

    a_r3_whole_block: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(host_ready) |-> (seen == '0));

    a_r9_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (s_valid && !s_ready) |=> (s_valid && $stable(s_data)));

    a_r6_narrow_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (s_valid && !wide_mode) |-> (s_data[31:16] == 16'h0000));
endmodule

bind hbf_ingress hbf_ingress_chk #(
    .DEPTH      (DEPTH),
    .BLOCK_WORDS(BLOCK_WORDS)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wide_mode (wide_mode),
    .host_ready(host_ready),
    .s_valid   (s_valid),
    .s_ready   (s_ready),
    .s_data    (s_data),
    .wr_accept (wr_accept),
    .fifo_full (fifo_full),
    .fifo_level(fifo_level)
);

// File: tb/sim_hbf_ingress.sv
`timescale 1ns/1ps
// Directed bench for hbf_ingress: one task per scenario.
module sim_hbf_ingress;
    localparam int DEPTH = 16;
    localparam int BLK   = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wide_mode = 1'b0;
    logic        host_wr = 1'b0;
    logic [15:0] host_data = '0;
    logic        s_ready = 1'b0;
    logic        host_ready;
    logic        s_valid;
    logic [31:0] s_data;

    int tests = 0;
    int fails = 0;

    always #4 clk = ~clk;

    hbf_ingress #(.DEPTH(DEPTH), .BLOCK_WORDS(BLK)) u0 (
        .clk(clk), .rst_n(rst_n), .wide_mode(wide_mode),
        .host_ready(host_ready), .host_wr(host_wr), .host_data(host_data),
        .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data)
    );

    // Record one check.
    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Reset in the given mode; check the idle outputs and the first grant.
    task automatic do_reset(input bit mode);
        @(negedge clk);
        rst_n = 1'b0; wide_mode = mode; host_wr = 1'b0; s_ready = 1'b0;
        repeat (3) begin
            @(negedge clk);
            chk(host_ready == 1'b0, "R1 ready in reset", 32'(host_ready), 0);
            chk(s_valid == 1'b0, "R1 valid in reset", 32'(s_valid), 0);
        end
        rst_n = 1'b1;
        @(negedge clk);
        chk(host_ready == 1'b1, "R2 first grant", 32'(host_ready), 1);
    endtask

    // Write one word once the block is granted (entered at a negedge).
    task automatic push_word(input logic [15:0] d);
        while (!host_ready) @(negedge clk);
        host_wr = 1'b1; host_data = d;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    // Check the head and consume it (entered at a negedge).
    task automatic pop_expect(input logic [31:0] exp, input string req);
        chk(s_valid == 1'b1, req, 32'(s_valid), 1);
        chk(s_data == exp, req, s_data, exp);
        s_ready = 1'b1;
        @(negedge clk);
        s_ready = 1'b0;
    endtask

    // Narrow mode: one block, gap, fall-through read, hold under backpressure.
    task automatic t_narrow_basic();
        do_reset(1'b0);
        for (int i = 0; i < BLK; i++) push_word(16'hA100 + 16'(i));
        chk(host_ready == 1'b0, "R3 ready drops after block", 32'(host_ready), 0);
        @(negedge clk);
        chk(host_ready == 1'b1, "R2 regrant with room", 32'(host_ready), 1);
        chk(s_valid == 1'b1 && s_data == 32'h0000A100, "R5 head visible", s_data, 32'h0000A100);
        @(negedge clk);
        chk(s_data == 32'h0000A100, "R9 held under backpressure", s_data, 32'h0000A100);
        for (int i = 0; i < BLK; i++) pop_expect(32'h0000A100 + 32'(i), "R6 narrow word");
        chk(s_valid == 1'b0, "R5 empty after drain", 32'(s_valid), 0);
    endtask

    // Fill completely, ignore stray strobes, reopen only at a whole block of room.
    task automatic t_fill_ignore();
        do_reset(1'b0);
        for (int i = 0; i < DEPTH; i++) push_word(16'h5000 + 16'(i));
        for (int i = 0; i < 5; i++) begin
            host_wr = 1'b1; host_data = 16'hDEAD;
            @(negedge clk);
            chk(host_ready == 1'b0, "R2 no grant when full", 32'(host_ready), 0);
        end
        host_wr = 1'b0;
        for (int i = 0; i < BLK - 1; i++) begin
            pop_expect(32'h00005000 + 32'(i), "R5 order");
            @(negedge clk);
            chk(host_ready == 1'b0, "R2 no grant below a block", 32'(host_ready), 0);
        end
        pop_expect(32'h00005000 + 32'(BLK - 1), "R5 order");
        chk(host_ready == 1'b0, "R2 grant one clock later", 32'(host_ready), 0);
        @(negedge clk);
        chk(host_ready == 1'b1, "R2 grant at block room", 32'(host_ready), 1);
        for (int i = BLK; i < DEPTH; i++) pop_expect(32'h00005000 + 32'(i), "R4 stray strobes not stored");
        chk(s_valid == 1'b0, "R4 nothing extra stored", 32'(s_valid), 0);
    endtask

    // Wide mode: pairing, half-pair wait, hold stable.
    task automatic t_wide();
        do_reset(1'b1);
        s_ready = 1'b0;
        push_word(16'h1234);
        @(negedge clk);
        chk(s_valid == 1'b0, "R8 half pair not valid", 32'(s_valid), 0);
        @(negedge clk);
        chk(s_valid == 1'b0, "R8 half pair still waiting", 32'(s_valid), 0);
        push_word(16'h5678);
        chk(s_valid == 1'b1 && s_data == 32'h12345678, "R7 pair upper first", s_data, 32'h12345678);
        @(negedge clk);
        chk(s_data == 32'h12345678, "R9 wide hold", s_data, 32'h12345678);
        pop_expect(32'h12345678, "R7 pair");
        push_word(16'hBEEF);
        push_word(16'hCAFE);
        @(negedge clk);
        pop_expect(32'hBEEFCAFE, "R7 second pair");
        @(negedge clk);
        chk(s_valid == 1'b0, "R8 nothing pending", 32'(s_valid), 0);
    endtask

    task automatic finish_run();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    initial begin
        t_narrow_basic();
        t_fill_ignore();
        t_wide();
        finish_run();
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (20000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end
endmodule